// File: doc/BRIEF.md
# Watch-Mode Wake Controller

This block sequences a chip through a clock-stopped watch state. While the chip runs in one of the three active modes (high-speed, medium-speed or sub-active), a sleep request with the watch-enable control set stops the clock and parks the controller in watch mode. At that moment it also records which of the two fast modes the chip should return to. During watch mode, the controller samples a set of wake sources: a timer overflow, the non-maskable interrupt, six external request lines with individual enables, and one peripheral request that its own enable and a CPU mask can block.

Any qualified wake source re-enables the clock. It also chooses the next mode. With the low-speed-on control at 1 the next mode is sub-active; with it at 0 it is the stored fast mode. The interrupt-processing start strobe is then held back by a down-counter. For a return to a fast mode, the counter runs for an oscillator-settling time chosen by a three-bit select. A return to sub-active waits a single cycle.

Priority is fixed. The reset pin overrides everything and returns the chip to high-speed mode with the counter cleared. The standby pin comes next: driving it low sends the controller to hardware standby from any state, and only reset leaves that state. The address bus and bus control outputs keep being driven through watch mode only when the port-output-enable control is set.

Top module: `watch_wake_ctrl`

## Requirements
- R1: While `res_n` is low and after it is released, `mode` is 0 (high-speed), `clk_en` is 1, `intr_start` is 0 and `bus_drive` is 1. A reset during a settling count cancels the pending strobe.
- R2: In an active mode (`mode` 0, 1 or 2), a cycle with `sleep_req`=1 and `watch_en`=1 moves `mode` to 3 (watch) with `clk_en`=0 at the next clock edge. With `watch_en`=0 the request has no effect.
- R3: In watch mode, each of the following exits at the next edge with `clk_en`=1: `tmr_ovf`=1, `nmi`=1 (even with `cpu_mask`=1), an `irq[i]` whose `irq_en[i]`=1, or `per_req` with `per_en`=1 and `cpu_mask`=0.
- R4: An `irq[i]` whose `irq_en[i]` is 0 does not end watch mode.
- R5: `per_req` does not end watch mode when `per_en` is 0 or `cpu_mask` is 1.
- R6: A wake with `lson`=1 enters `mode` 2 (sub-active). `intr_start` then pulses one cycle after the mode change.
- R7: A wake with `lson`=0 enters `mode` 1 (medium-speed) if `med_sel` was 1 on the sleep-request cycle, and `mode` 0 otherwise. Later changes to `med_sel` have no effect.
- R8: After a wake into mode 0 or 1, `intr_start` is a single-cycle pulse. It arrives exactly 2^(3+`sts_sel`) cycles after the cycle in which the mode changed, so codes 0..7 give 8..1024 cycles.
- R9: `stby_n`=0 moves `mode` to 4 (hardware standby) at the next edge, with `clk_en`=0 and `bus_drive`=0. This holds from any mode, including watch with a wake present and a settling count in progress. Only reset leaves mode 4, and no `intr_start` occurs there.
- R10: In watch mode `bus_drive` equals `ope`. In active modes it is 1.
- R11: Wake sources have no effect outside watch mode: they change neither `mode` nor `intr_start`.
- R12: A sleep request is ignored while a settling count is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| res_n | input | 1 | Reset pin, active low, asynchronous |
| stby_n | input | 1 | Standby pin, active low |
| sleep_req | input | 1 | Sleep request strobe from the CPU |
| watch_en | input | 1 | Selects watch mode on a sleep request |
| med_sel | input | 1 | Medium-speed return flag, captured at watch entry |
| lson | input | 1 | Low-speed-on control: 1 wakes into sub-active |
| sts_sel | input | 3 | Oscillator-settling time select |
| ope | input | 1 | Keep bus outputs driven during watch mode |
| tmr_ovf | input | 1 | Timer overflow interrupt |
| nmi | input | 1 | Non-maskable interrupt pin |
| irq | input | 6 | External interrupt request lines |
| irq_en | input | 6 | Per-line enables for `irq` |
| per_req | input | 1 | Peripheral interrupt request |
| per_en | input | 1 | Peripheral interrupt enable |
| cpu_mask | input | 1 | CPU mask for maskable peripheral interrupts |
| mode | output | 3 | 0 high-speed, 1 medium-speed, 2 sub-active, 3 watch, 4 hardware standby |
| clk_en | output | 1 | Clock enable to all logic |
| intr_start | output | 1 | One-cycle strobe that starts interrupt processing |
| bus_drive | output | 1 | Address bus and bus control outputs are driven |

## Verification
The hardest case to reach is a standby pin that falls while the controller is in the middle of leaving watch mode. This includes the cycle in which a wake source is already present, and the long 1024-cycle settling window before the strobe fires. The bench applies the standby pin and a wake source on the same falling edge. It then confirms that hardware standby wins and that no strobe emerges for longer than the longest settling time. In a separate run it drops the standby pin several cycles into a count and watches the full window.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
    typedef enum logic [2:0] {
        MODE_HIGH   = 3'd0,
        MODE_MED    = 3'd1,
        MODE_SUB    = 3'd2,
        MODE_WATCH  = 3'd3,
        MODE_HWSTBY = 3'd4
    } pmode_e;
endpackage

// File: rtl/wwc_wake_qual.sv
// Qualifies every wake source; only meaningful while the controller is in watch mode.
module wwc_wake_qual #(
    parameter int NUM_IRQ = 6
) (
    input  logic               in_watch,
    input  logic               tmr_ovf,
    input  logic               nmi,
    input  logic [NUM_IRQ-1:0] irq,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               per_req,
    input  logic               per_en,
    input  logic               cpu_mask,
    output logic               wake
);
    logic [NUM_IRQ-1:0] irq_hit;

    // each external line passes only through its own enable (R4)
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        assign irq_hit[i] = irq[i] & irq_en[i];
    end

    logic nmi_hit;
    logic mask_hit;

    always_comb begin
        nmi_hit  = nmi;                                  // never masked
        mask_hit = tmr_ovf | (|irq_hit)
                 | (per_req & per_en & ~cpu_mask);       // R5
        wake     = in_watch & (nmi_hit | mask_hit);      // R11
    end
endmodule

// File: rtl/wwc_settle_timer.sv
// Down-counter that delays the interrupt start strobe after a wake.
module wwc_settle_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             res_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             abort,
    output logic             start,
    output logic             busy
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic             start;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (abort) begin
            s_d.pend = 1'b0;
            s_d.cnt  = '0;
        end else if (load) begin
            s_d.pend = 1'b1;
            s_d.cnt  = load_val;
        end else if (s_q.pend) begin
            if (s_q.cnt == '0) begin
                s_d.pend  = 1'b0;
                s_d.start = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge res_n) begin
        if (!res_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start = s_q.start;
    assign busy  = s_q.pend;
endmodule

// File: rtl/wwc_mode_fsm.sv
// Mode sequencer: entry into watch, wake target selection, standby override.
module wwc_mode_fsm
    import wwc_pkg::*;
(
    input  logic   clk,
    input  logic   res_n,
    input  logic   stby_n,
    input  logic   sleep_req,
    input  logic   watch_en,
    input  logic   med_sel,
    input  logic   lson,
    input  logic   wake,
    input  logic   settle_busy,
    output pmode_e mode,
    output logic   clk_en,
    output logic   load_settle
);
    typedef struct packed {
        pmode_e mode;
        logic   clk_en;
        logic   med;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        load_settle = 1'b0;
        if (!stby_n) begin
            s_d.mode   = MODE_HWSTBY;   // beats any pending wake (R9)
            s_d.clk_en = 1'b0;
        end else begin
            case (s_q.mode)
                MODE_HIGH, MODE_MED, MODE_SUB: begin
                    if (sleep_req && watch_en && !settle_busy) begin
                        s_d.mode   = MODE_WATCH;
                        s_d.clk_en = 1'b0;
                        s_d.med    = med_sel;
                    end
                end
                MODE_WATCH: begin
                    if (wake) begin
                        load_settle = 1'b1;
                        s_d.clk_en  = 1'b1;
                        if (lson)       s_d.mode = MODE_SUB;
                        else if (s_q.med) s_d.mode = MODE_MED;
                        else            s_d.mode = MODE_HIGH;
                    end
                end
                MODE_HWSTBY: s_d = s_q;
                default: begin
                    s_d.mode   = MODE_HIGH;
                    s_d.clk_en = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge res_n) begin
        if (!res_n) begin
            s_q.mode   <= MODE_HIGH;
            s_q.clk_en <= 1'b1;
            s_q.med    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode   = s_q.mode;
    assign clk_en = s_q.clk_en;
endmodule

// File: rtl/watch_wake_ctrl.sv
module watch_wake_ctrl
    import wwc_pkg::*;
#(
    parameter int NUM_IRQ  = 6,
    parameter int STS_W    = 3,
    parameter int BASE_LOG = 3
) (
    input  logic               clk,
    input  logic               res_n,
    input  logic               stby_n,
    input  logic               sleep_req,
    input  logic               watch_en,
    input  logic               med_sel,
    input  logic               lson,
    input  logic [STS_W-1:0]   sts_sel,
    input  logic               ope,
    input  logic               tmr_ovf,
    input  logic               nmi,
    input  logic [NUM_IRQ-1:0] irq,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               per_req,
    input  logic               per_en,
    input  logic               cpu_mask,
    output logic [2:0]         mode,
    output logic               clk_en,
    output logic               intr_start,
    output logic               bus_drive
);
    // longest wait is 2^(BASE_LOG + 2^STS_W - 1) cycles; counter holds that minus one
    localparam int CNT_W = BASE_LOG + (1 << STS_W) - 1;

    pmode_e           cur_mode;
    logic             wake;
    logic             load_settle;
    logic             settle_busy;
    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] load_val;

    wwc_wake_qual #(.NUM_IRQ(NUM_IRQ)) u_qual (
        .in_watch (cur_mode == MODE_WATCH),
        .tmr_ovf  (tmr_ovf),
        .nmi      (nmi),
        .irq      (irq),
        .irq_en   (irq_en),
        .per_req  (per_req),
        .per_en   (per_en),
        .cpu_mask (cpu_mask),
        .wake     (wake)
    );

    wwc_mode_fsm u_fsm (
        .clk         (clk),
        .res_n       (res_n),
        .stby_n      (stby_n),
        .sleep_req   (sleep_req),
        .watch_en    (watch_en),
        .med_sel     (med_sel),
        .lson        (lson),
        .wake        (wake),
        .settle_busy (settle_busy),
        .mode        (cur_mode),
        .clk_en      (clk_en),
        .load_settle (load_settle)
    );

    // the largest code shifts the one out of range; minus one then wraps to all ones
    always_comb begin
        span     = CNT_W'(1) << (BASE_LOG + int'(sts_sel));
        load_val = lson ? '0 : (span - CNT_W'(1));
    end

    wwc_settle_timer #(.CNT_W(CNT_W)) u_settle (
        .clk      (clk),
        .res_n    (res_n),
        .load     (load_settle),
        .load_val (load_val),
        .abort    (!stby_n),
        .start    (intr_start),
        .busy     (settle_busy)
    );

    always_comb begin
        case (cur_mode)
            MODE_WATCH:  bus_drive = ope;
            MODE_HWSTBY: bus_drive = 1'b0;
            default:     bus_drive = 1'b1;
        endcase
    end

    assign mode = cur_mode;
endmodule

// File: rtl/watch_wake_ctrl_chk.sv
module watch_wake_ctrl_chk #(
    parameter int NUM_IRQ = 6
) (
    input logic               clk,
    input logic               res_n,
    input logic               stby_n,
    input logic               tmr_ovf,
    input logic               nmi,
    input logic [NUM_IRQ-1:0] irq,
    input logic [NUM_IRQ-1:0] irq_en,
    input logic               per_req,
    input logic               per_en,
    input logic               cpu_mask,
    input logic [2:0]         mode,
    input logic               clk_en,
    input logic               intr_start
);
    p_watch_clk_off_r2: assert property (@(posedge clk) disable iff (!res_n)
        (mode == 3'd3) |-> !clk_en);

    p_no_spurious_exit_r4: assert property (@(posedge clk) disable iff (!res_n)
        (mode == 3'd3 && stby_n && !tmr_ovf && !nmi && ((irq & irq_en) == '0)
         && !(per_req && per_en && !cpu_mask)) |=> (mode == 3'd3));

    p_masked_periph_r5: assert property (@(posedge clk) disable iff (!res_n)
        (mode == 3'd3 && stby_n && !tmr_ovf && !nmi && ((irq & irq_en) == '0)
         && per_req && cpu_mask) |=> (mode == 3'd3));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!res_n)
        intr_start |=> !intr_start);

    p_strobe_clocked_r8: assert property (@(posedge clk) disable iff (!res_n)
        intr_start |-> clk_en);

    p_standby_entry_r9: assert property (@(posedge clk) disable iff (!res_n)
        !stby_n |=> (mode == 3'd4 && !clk_en));

    p_standby_hold_r9: assert property (@(posedge clk) disable iff (!res_n)
        (mode == 3'd4) |=> (mode == 3'd4 && !intr_start));
endmodule

bind watch_wake_ctrl watch_wake_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .res_n      (res_n),
    .stby_n     (stby_n),
    .tmr_ovf    (tmr_ovf),
    .nmi        (nmi),
    .irq        (irq),
    .irq_en     (irq_en),
    .per_req    (per_req),
    .per_en     (per_en),
    .cpu_mask   (cpu_mask),
    .mode       (mode),
    .clk_en     (clk_en),
    .intr_start (intr_start)
);

// File: tb/sim_watch_wake_ctrl.sv
`timescale 1ns/1ps
module sim_watch_wake_ctrl;
    logic       clk = 1'b0;
    logic       res_n = 1'b0;
    logic       stby_n = 1'b1;
    logic       sleep_req = 1'b0;
    logic       watch_en = 1'b0;
    logic       med_sel = 1'b0;
    logic       lson = 1'b0;
    logic [2:0] sts_sel = 3'd0;
    logic       ope = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       nmi = 1'b0;
    logic [5:0] irq = 6'h00;
    logic [5:0] irq_en = 6'h00;
    logic       per_req = 1'b0;
    logic       per_en = 1'b0;
    logic       cpu_mask = 1'b0;
    logic [2:0] mode;
    logic       clk_en;
    logic       intr_start;
    logic       bus_drive;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    watch_wake_ctrl u0 (
        .clk(clk), .res_n(res_n), .stby_n(stby_n), .sleep_req(sleep_req),
        .watch_en(watch_en), .med_sel(med_sel), .lson(lson), .sts_sel(sts_sel),
        .ope(ope), .tmr_ovf(tmr_ovf), .nmi(nmi), .irq(irq), .irq_en(irq_en),
        .per_req(per_req), .per_en(per_en), .cpu_mask(cpu_mask),
        .mode(mode), .clk_en(clk_en), .intr_start(intr_start), .bus_drive(bus_drive)
    );

    typedef struct packed {
        logic       tmr;
        logic       nm;
        logic [5:0] rq;
        logic [5:0] rq_en;
        logic       per;
        logic       pen;
        logic       msk;
        logic       ls;
        logic       med;
        logic [2:0] sts;
        logic       exp_wake;
        logic [2:0] exp_mode;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd0}, // R3 timer -> high
        '{1'b0, 1'b1, 6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd5, 1'b1, 3'd2}, // R6 nmi -> sub
        '{1'b0, 1'b0, 6'h04, 6'h04, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 3'd1}, // R7 irq2 -> med
        '{1'b0, 1'b0, 6'h04, 6'h3B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd3}, // R4 disabled line
        '{1'b0, 1'b0, 6'h00, 6'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 3'd0}, // R8 longest wait
        '{1'b0, 1'b0, 6'h00, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd3}, // R5 disabled
        '{1'b0, 1'b0, 6'h00, 6'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 3'd3}, // R5 masked
        '{1'b0, 1'b0, 6'h20, 6'h20, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1, 3'd2}, // R6 irq5 -> sub
        '{1'b0, 1'b1, 6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 3'd0}, // R3 nmi ignores mask
        '{1'b0, 1'b0, 6'h01, 6'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 3'd1}  // R8 irq0 -> med
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_wakes();
        tmr_ovf = 1'b0; nmi = 1'b0; irq = 6'h00; irq_en = 6'h00;
        per_req = 1'b0; per_en = 1'b0; cpu_mask = 1'b0;
    endtask

    task automatic do_reset();
        res_n = 1'b0; stby_n = 1'b1; clear_wakes();
        tick(2);
        res_n = 1'b1;
        tick(1);
    endtask

    task automatic enter_watch(input logic med);
        sleep_req = 1'b1; watch_en = 1'b1; med_sel = med;
        tick(1);
        sleep_req = 1'b0; watch_en = 1'b0;
    endtask

    // cycles from the mode change until intr_start shows, limited
    task automatic wait_strobe(input int limit, output int cyc);
        cyc = 0;
        while (!intr_start && cyc < limit) begin
            tick(1);
            cyc++;
        end
    endtask

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        int exp_n;
        int seen;
        tick(1);
        // R1 values while and after reset
        check(mode == 3'd0 && clk_en && !intr_start && bus_drive, "R1", int'(mode), 0);
        do_reset();
        check(mode == 3'd0 && clk_en && !intr_start && bus_drive, "R1", int'(mode), 0);

        // R11 wake sources in an active mode
        tmr_ovf = 1'b1; nmi = 1'b1; irq = 6'h3F; irq_en = 6'h3F;
        tick(3);
        clear_wakes();
        check(mode == 3'd0 && !intr_start, "R11", int'(mode), 0);

        // R2 sleep without watch enable
        sleep_req = 1'b1; watch_en = 1'b0;
        tick(1);
        sleep_req = 1'b0;
        check(mode == 3'd0, "R2", int'(mode), 0);
        ope = 1'b0;
        enter_watch(1'b0);
        check(mode == 3'd3 && !clk_en, "R2", int'(mode), 3);
        // R10 bus outputs follow ope in watch
        check(bus_drive == 1'b0, "R10", int'(bus_drive), 0);
        ope = 1'b1;
        tick(1);
        check(bus_drive == 1'b1, "R10", int'(bus_drive), 1);
        lson = 1'b0; sts_sel = 3'd0; nmi = 1'b1;
        tick(1);
        clear_wakes();
        wait_strobe(2000, cyc);

        // table walk: R3..R8
        for (int v = 0; v < NVEC; v++) begin
            enter_watch(VEC[v].med);
            lson = VEC[v].ls; sts_sel = VEC[v].sts;
            tmr_ovf = VEC[v].tmr; nmi = VEC[v].nm; irq = VEC[v].rq; irq_en = VEC[v].rq_en;
            per_req = VEC[v].per; per_en = VEC[v].pen; cpu_mask = VEC[v].msk;
            tick(1);
            check(mode == VEC[v].exp_mode, "R3", int'(mode), int'(VEC[v].exp_mode));
            if (VEC[v].exp_wake) begin
                clear_wakes();
                check(clk_en == 1'b1, "R3", int'(clk_en), 1);
                exp_n = VEC[v].ls ? 1 : (8 << VEC[v].sts);
                wait_strobe(2000, cyc);
                check(cyc == exp_n, VEC[v].ls ? "R6" : "R8", cyc, exp_n);
                tick(1);
                check(intr_start == 1'b0, "R8", int'(intr_start), 0);
            end else begin
                tick(2);
                check(mode == 3'd3 && !intr_start, VEC[v].pen ? "R5" : "R4", int'(mode), 3);
                clear_wakes();
                lson = 1'b0; nmi = 1'b1;
                tick(1);
                nmi = 1'b0;
                wait_strobe(2000, cyc);
            end
        end

        // R7 flag captured at entry, not later
        enter_watch(1'b1);
        med_sel = 1'b0; lson = 1'b0; sts_sel = 3'd1; tmr_ovf = 1'b1;
        tick(1);
        clear_wakes();
        check(mode == 3'd1, "R7", int'(mode), 1);
        // R12 sleep during pending count
        sleep_req = 1'b1; watch_en = 1'b1;
        tick(1);
        sleep_req = 1'b0; watch_en = 1'b0;
        check(mode == 3'd1, "R12", int'(mode), 1);
        wait_strobe(2000, cyc);
        check(cyc == 15, "R8", cyc, 15);

        // R9 standby and wake in the same cycle
        enter_watch(1'b0);
        stby_n = 1'b0; nmi = 1'b1;
        tick(1);
        stby_n = 1'b1;
        check(mode == 3'd4 && !clk_en && !bus_drive, "R9", int'(mode), 4);
        tick(3);
        check(mode == 3'd4, "R9", int'(mode), 4);
        clear_wakes();
        sleep_req = 1'b1; watch_en = 1'b1;
        tick(1);
        sleep_req = 1'b0; watch_en = 1'b0;
        check(mode == 3'd4, "R9", int'(mode), 4);
        do_reset();
        check(mode == 3'd0 && clk_en, "R1", int'(mode), 0);

        // R9 standby during a long count
        enter_watch(1'b0);
        sts_sel = 3'd7; tmr_ovf = 1'b1;
        tick(1);
        clear_wakes();
        tick(5);
        stby_n = 1'b0;
        tick(1);
        stby_n = 1'b1;
        seen = 0;
        for (int k = 0; k < 1100; k++) begin
            if (intr_start) seen++;
            tick(1);
        end
        check(seen == 0 && mode == 3'd4, "R9", seen, 0);

        // R1 reset cancels a pending count
        do_reset();
        enter_watch(1'b0);
        sts_sel = 3'd7; nmi = 1'b1;
        tick(1);
        clear_wakes();
        tick(5);
        do_reset();
        seen = 0;
        for (int k = 0; k < 1100; k++) begin
            if (intr_start) seen++;
            tick(1);
        end
        check(seen == 0 && mode == 3'd0, "R1", seen, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule